// File: doc/BRIEF.md
# Bidirectional G.711 Sample Compander

This block sits between a serial audio port and the linear sample datapath. It works in both directions. On the transmit side it takes 16-bit two's-complement samples and turns each one into an 8-bit logarithmic G.711 code, either mu-law or A-law. On the receive side it takes 8-bit codes and expands each one back to a 16-bit linear sample. The 8-bit code always travels in the upper byte of a 16-bit word.

Each direction has its own control bits:

- a companding enable;
- a law select (0 = mu-law, 1 = A-law);
- a byte-mode bit.

When companding is on for either direction, the port word length is 8 bits. A direction that is not companding then moves plain truncated 8-bit linear data. When no companding is on and a direction's byte-mode bit is clear, that direction passes its samples through unchanged.

Each direction has one register stage. A sample accepted with its valid bit appears one cycle later with an output valid. Between samples the output holds its last value.

Top module: `g711_compander`

## Requirements
- R1: With tx_en_i=1 and tx_alaw_i=0, a transmit sample is encoded to mu-law as follows.
  - Take bits 15:2 as a signed 14-bit value and its magnitude.
  - Add 33 to the magnitude and clamp the result to 8191.
  - The segment (0..7) is the position of the leading one minus 5. The mantissa is the 4 bits below the leading one.
  - Form {sign (1 = negative), segment, mantissa} and invert all 8 bits.
  - Place the result in tx_word_o[15:8] with tx_word_o[7:0] = 0.
- R2: With tx_en_i=1 and tx_alaw_i=1, a transmit sample is encoded to A-law as follows.
  - Take bits 15:3 as a signed 13-bit value x. The magnitude is x when x >= 0 and -x-1 otherwise.
  - Magnitudes below 32 use segment 0 with mantissa = magnitude[4:1]. Otherwise the segment is the leading-one position minus 4, and the mantissa is the 4 bits below the leading one.
  - Form {sign (1 = non-negative), segment, mantissa} and XOR it with 0x55.
  - Place the result in tx_word_o[15:8] with the low byte 0.
- R3: With rx_en_i=1 and rx_alaw_i=0, code c = rx_word_i[15:8] is decoded as follows.
  - Let u = ~c, s = u[6:4] and m = u[3:0].
  - The magnitude is ((8m+132) << s) - 132.
  - rx_lin_o is this magnitude, negated when u[7]=1.
- R4: With rx_en_i=1 and rx_alaw_i=1, code c is decoded as follows.
  - Let a = c ^ 0x55, s = a[6:4] and m = a[3:0].
  - The magnitude is 16m+8 for s=0, and (16m+264) << (s-1) otherwise.
  - rx_lin_o is this magnitude, negated when a[7]=0.
- R5: A direction passes its 16-bit input unchanged when all three of these hold: its own enable is 0, the other direction's enable is 0, and its byte-mode bit is 0.
- R6: When tx_en_i=0 and either tx_byte_mode_i=1 or rx_en_i=1, tx_word_o = {tx_lin_i[15:8], 8'h00}.
- R7: When rx_en_i=0 and either rx_byte_mode_i=1 or tx_en_i=1, rx_lin_o = {rx_word_i[15:8], 8'h00}.
- R8: The law select and mode of one direction have no effect on the other direction's output.
- R9: Each output valid equals its input valid one cycle earlier. In a cycle without input valid, the output data holds its previous value.
- R10: While rst_ni is low, both valid outputs and both data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit companding enable |
| tx_alaw_i | input | 1 | Transmit law: 0 mu-law, 1 A-law |
| tx_byte_mode_i | input | 1 | Transmit 8-bit linear mode |
| rx_en_i | input | 1 | Receive companding enable |
| rx_alaw_i | input | 1 | Receive law: 0 mu-law, 1 A-law |
| rx_byte_mode_i | input | 1 | Receive 8-bit linear mode |
| tx_valid_i | input | 1 | Transmit sample valid |
| tx_lin_i | input | 16 | Transmit linear sample |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_word_o | output | 16 | Transmit word, code in MSBs |
| rx_valid_i | input | 1 | Receive word valid |
| rx_word_i | input | 16 | Receive word, code in MSBs |
| rx_valid_o | output | 1 | Receive sample valid |
| rx_lin_o | output | 16 | Receive linear sample |

## Verification
The bench builds the block with its default parameters: a 16-bit linear bus and an 8-bit code. With these defaults the whole 16-bit sample range reaches both encoders. That range includes the clamp region of the mu-law bias and the one's-complement edge at the most negative A-law input. On the receive side, every 8-bit code is reachable by both decoders. Random control settings cover every pairing of the two directions' modes, including cross-coupled 8-bit mode. Directed codes and samples cover the signed zero codes, full scale and the segment boundaries.

// File: rtl/g711_pkg.sv
package g711_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_LIN8 = 2'd1,
    MODE_COMP = 2'd2
  } lane_mode_e;

  // Companding on either side forces 8-bit word length for both
  function automatic lane_mode_e sel_mode(input logic own_en, input logic other_en,
                                          input logic own_byte);
    if (own_en) return MODE_COMP;
    if (other_en || own_byte) return MODE_LIN8;
    return MODE_PASS;
  endfunction
endpackage

// File: rtl/g711_encoder.sv
module g711_encoder #(
  parameter int LIN_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic [LIN_W-1:0]  lin_i,
  input  logic              alaw_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int MU_W   = 14;
  localparam int AL_W   = 13;
  localparam int MU_CLP = 8191;
  localparam int MU_BIAS = 33;

  logic signed [MU_W-1:0] mu_x;
  logic                   mu_neg;
  logic [MU_W-1:0]        mu_mag;
  logic [MU_W:0]          mu_biased;
  logic [12:0]            mu_clp;
  logic [3:0]             mu_pos;
  logic [2:0]             mu_seg;
  logic [3:0]             mu_man;

  logic signed [AL_W-1:0] a_x;
  logic                   a_neg;
  logic [11:0]            a_mag;
  logic [3:0]             a_pos;
  logic [2:0]             a_seg;
  logic [3:0]             a_man;

  assign mu_x      = lin_i[LIN_W-1 -: MU_W];
  assign mu_neg    = mu_x[MU_W-1];
  assign mu_mag    = mu_neg ? MU_W'(-mu_x) : MU_W'(mu_x);
  assign mu_biased = {1'b0, mu_mag} + (MU_W+1)'(MU_BIAS);
  assign mu_clp    = (mu_biased > (MU_W+1)'(MU_CLP)) ? 13'h1fff : mu_biased[12:0];

  always_comb begin
    mu_pos = 4'd5;
    for (int i = 6; i < 13; i++) begin
      if (mu_clp[i]) mu_pos = 4'(i);
    end
    mu_seg = 3'(mu_pos - 4'd5);
    mu_man = 4'(mu_clp >> (mu_pos - 4'd4));
  end

  assign a_x   = lin_i[LIN_W-1 -: AL_W];
  assign a_neg = a_x[AL_W-1];
  assign a_mag = a_neg ? ~a_x[11:0] : a_x[11:0];

  always_comb begin
    a_pos = 4'd4;
    for (int i = 5; i < 12; i++) begin
      if (a_mag[i]) a_pos = 4'(i);
    end
    a_seg = 3'(a_pos - 4'd4);
    a_man = (a_pos == 4'd4) ? a_mag[4:1] : 4'(a_mag >> (a_pos - 4'd4));
  end

  always_comb begin
    if (alaw_i) code_o = CODE_W'({~a_neg, a_seg, a_man} ^ 8'h55);
    else        code_o = CODE_W'(~{mu_neg, mu_seg, mu_man});
  end
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder #(
  parameter int LIN_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              alaw_i,
  output logic [LIN_W-1:0]  lin_o
);
  localparam int EXT_W = LIN_W - 16;

  logic [7:0]  u;
  logic [15:0] mu_t;
  logic [15:0] mu_mag;
  logic [15:0] mu_val;
  logic [7:0]  a;
  logic [15:0] a_base;
  logic [15:0] a_mag;
  logic [15:0] a_val;
  logic [15:0] val;

  assign u      = ~code_i[7:0];
  assign mu_t   = ({8'b0, u[3:0], 3'b0} + 16'd132) << u[6:4];
  assign mu_mag = mu_t - 16'd132;
  assign mu_val = u[7] ? (16'd0 - mu_mag) : mu_mag;

  assign a      = code_i[7:0] ^ 8'h55;
  assign a_base = {8'b0, a[3:0], 4'b0};
  assign a_mag  = (a[6:4] == 3'd0) ? (a_base + 16'd8)
                                   : ((a_base + 16'd264) << (a[6:4] - 3'd1));
  assign a_val  = a[7] ? a_mag : (16'd0 - a_mag);

  assign val   = alaw_i ? a_val : mu_val;
  // Midpoint sits left-justified on the linear bus
  assign lin_o = LIN_W'(val) << EXT_W;
endmodule

// File: rtl/g711_lane.sv
module g711_lane
  import g711_pkg::*;
#(
  parameter int LIN_W  = 16,
  parameter int CODE_W = 8,
  parameter bit IS_TX  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lane_mode_e       mode_i,
  input  logic             alaw_i,
  input  logic             valid_i,
  input  logic [LIN_W-1:0] data_i,
  output logic             valid_o,
  output logic [LIN_W-1:0] data_o
);
  localparam int PAD_W = LIN_W - CODE_W;

  logic [LIN_W-1:0] comp_word;
  logic [LIN_W-1:0] lin8_word;
  logic [LIN_W-1:0] nxt_word;

  generate
    if (IS_TX) begin : g_tx
      logic [CODE_W-1:0] code;
      g711_encoder #(.LIN_W(LIN_W), .CODE_W(CODE_W)) u_enc (
        .lin_i (data_i),
        .alaw_i(alaw_i),
        .code_o(code)
      );
      assign comp_word = {code, {PAD_W{1'b0}}};
    end else begin : g_rx
      g711_decoder #(.LIN_W(LIN_W), .CODE_W(CODE_W)) u_dec (
        .code_i(data_i[LIN_W-1 -: CODE_W]),
        .alaw_i(alaw_i),
        .lin_o (comp_word)
      );
    end
  endgenerate

  assign lin8_word = {data_i[LIN_W-1 -: CODE_W], {PAD_W{1'b0}}};

  always_comb begin
    case (mode_i)
      MODE_COMP: nxt_word = comp_word;
      MODE_LIN8: nxt_word = lin8_word;
      default:   nxt_word = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= nxt_word;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // R5
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_PASS) |=> data_o == $past(data_i));
  // R6 R7
  lin8_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_LIN8) |=>
      (data_o[PAD_W-1:0] == '0 &&
       data_o[LIN_W-1 -: CODE_W] == $past(data_i[LIN_W-1 -: CODE_W])));
endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
#(
  parameter int LIN_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             tx_alaw_i,
  input  logic             tx_byte_mode_i,
  input  logic             rx_en_i,
  input  logic             rx_alaw_i,
  input  logic             rx_byte_mode_i,
  input  logic             tx_valid_i,
  input  logic [LIN_W-1:0] tx_lin_i,
  output logic             tx_valid_o,
  output logic [LIN_W-1:0] tx_word_o,
  input  logic             rx_valid_i,
  input  logic [LIN_W-1:0] rx_word_i,
  output logic             rx_valid_o,
  output logic [LIN_W-1:0] rx_lin_o
);
  localparam int PAD_W = LIN_W - CODE_W;

  lane_mode_e tx_mode;
  lane_mode_e rx_mode;

  assign tx_mode = sel_mode(tx_en_i, rx_en_i, tx_byte_mode_i);
  assign rx_mode = sel_mode(rx_en_i, tx_en_i, rx_byte_mode_i);

  g711_lane #(.LIN_W(LIN_W), .CODE_W(CODE_W), .IS_TX(1'b1)) u_tx_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (tx_mode),
    .alaw_i (tx_alaw_i),
    .valid_i(tx_valid_i),
    .data_i (tx_lin_i),
    .valid_o(tx_valid_o),
    .data_o (tx_word_o)
  );

  g711_lane #(.LIN_W(LIN_W), .CODE_W(CODE_W), .IS_TX(1'b0)) u_rx_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (rx_mode),
    .alaw_i (rx_alaw_i),
    .valid_i(rx_valid_i),
    .data_i (rx_word_i),
    .valid_o(rx_valid_o),
    .data_o (rx_lin_o)
  );

  // R1 R2
  tx_code_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_en_i) |=> tx_word_o[PAD_W-1:0] == '0);
  // R6
  tx_cross_lin8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_en_i && rx_en_i) |=>
      tx_word_o == {$past(tx_lin_i[LIN_W-1 -: CODE_W]), {PAD_W{1'b0}}});
  // R7
  rx_cross_lin8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_en_i && tx_en_i) |=>
      rx_lin_o == {$past(rx_word_i[LIN_W-1 -: CODE_W]), {PAD_W{1'b0}}});
  // R3 positive zero code expands to zero
  rx_mu_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_en_i && !rx_alaw_i && rx_word_i[LIN_W-1 -: CODE_W] == 8'hff)
      |=> rx_lin_o == '0);
endmodule

// File: tb/g711_compander_bench.sv
module g711_compander_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, tx_alaw = 0, tx_byte = 0, rx_en = 0, rx_alaw = 0, rx_byte = 0;
  logic tx_v = 0, rx_v = 0;
  logic [15:0] tx_lin = '0, rx_word = '0;
  logic tx_vo, rx_vo;
  logic [15:0] tx_wo, rx_lo;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_tx = '0, exp_rx = '0;
  logic exp_txv = 0, exp_rxv = 0;
  string tx_tag = "R10", rx_tag = "R10";

  always #2 clk = ~clk;

  g711_compander u_g711_compander (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_en_i(tx_en), .tx_alaw_i(tx_alaw), .tx_byte_mode_i(tx_byte),
    .rx_en_i(rx_en), .rx_alaw_i(rx_alaw), .rx_byte_mode_i(rx_byte),
    .tx_valid_i(tx_v), .tx_lin_i(tx_lin), .tx_valid_o(tx_vo), .tx_word_o(tx_wo),
    .rx_valid_i(rx_v), .rx_word_i(rx_word), .rx_valid_o(rx_vo), .rx_lin_o(rx_lo)
  );

  function automatic logic [7:0] ref_mu_enc(logic [15:0] s);
    int v, seg;
    logic [7:0] mask, r;
    v = int'($signed(s)) >>> 2;
    if (v < 0) begin v = -v; mask = 8'h7f; end else mask = 8'hff;
    v = v + 33;
    if (v > 8191) v = 8191;
    seg = 0;
    while (v >= (64 << seg)) seg++;
    r = 8'((seg << 4) | ((v >> (seg + 1)) & 15));
    return r ^ mask;
  endfunction

  function automatic logic [7:0] ref_a_enc(logic [15:0] s);
    int v, seg;
    logic [7:0] mask, r;
    v = int'($signed(s)) >>> 3;
    if (v >= 0) mask = 8'hd5; else begin mask = 8'h55; v = -v - 1; end
    seg = 0;
    while (v >= (32 << seg)) seg++;
    if (seg < 2) r = 8'((seg << 4) | ((v >> 1) & 15));
    else         r = 8'((seg << 4) | ((v >> seg) & 15));
    return r ^ mask;
  endfunction

  function automatic logic [15:0] ref_mu_dec(logic [7:0] c);
    int t;
    logic [7:0] u;
    u = ~c;
    t = ((int'(u[3:0]) << 3) + 132) << int'(u[6:4]);
    return u[7] ? 16'(132 - t) : 16'(t - 132);
  endfunction

  function automatic logic [15:0] ref_a_dec(logic [7:0] c);
    int t, seg;
    logic [7:0] a;
    a = c ^ 8'h55;
    t = int'(a[3:0]) << 4;
    seg = int'(a[6:4]);
    if (seg == 0) t = t + 8;
    else t = (t + 264) << (seg - 1);
    return a[7] ? 16'(t) : 16'(-t);
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, compute expectation, check at next negedge
  task automatic step(logic te, logic ta, logic tb, logic re, logic ra, logic rb,
                      logic tv, logic [15:0] tl, logic rv, logic [15:0] rw);
    tx_en = te; tx_alaw = ta; tx_byte = tb; rx_en = re; rx_alaw = ra; rx_byte = rb;
    tx_v = tv; tx_lin = tl; rx_v = rv; rx_word = rw;
    exp_txv = tv;
    exp_rxv = rv;
    if (tv) begin
      if (te) begin
        exp_tx = {(ta ? ref_a_enc(tl) : ref_mu_enc(tl)), 8'h00};
        tx_tag = ta ? "R2" : "R1";
      end else if (re || tb) begin
        exp_tx = {tl[15:8], 8'h00}; tx_tag = "R6";
      end else begin
        exp_tx = tl; tx_tag = "R5";
      end
    end else tx_tag = "R9";
    if (rv) begin
      if (re) begin
        exp_rx = ra ? ref_a_dec(rw[15:8]) : ref_mu_dec(rw[15:8]);
        rx_tag = ra ? "R4" : "R3";
      end else if (te || rb) begin
        exp_rx = {rw[15:8], 8'h00}; rx_tag = "R7";
      end else begin
        exp_rx = rw; rx_tag = "R5";
      end
    end else rx_tag = "R9";
    @(negedge clk);
    check("R9", "tx valid", {15'b0, tx_vo}, {15'b0, exp_txv});
    check("R9", "rx valid", {15'b0, rx_vo}, {15'b0, exp_rxv});
    // R8: each side checked against a model that ignores the other side's law
    check(tx_tag, "tx word", tx_wo, exp_tx);
    check(rx_tag, "rx lin", rx_lo, exp_rx);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lins [10];
    logic [7:0]  codes [9];
    void'($urandom(32'd7130));
    lins = '{16'h0000, 16'h0001, 16'hffff, 16'h7fff, 16'h8000,
             16'h0084, 16'hff7c, 16'h00ff, 16'h0100, 16'h7f00};
    codes = '{8'h00, 8'hff, 8'h7f, 8'h80, 8'h55, 8'hd5, 8'h2a, 8'haa, 8'h0f};
    repeat (3) @(negedge clk);
    // R10
    check("R10", "reset tx", {tx_vo, tx_wo[14:0]}, 16'h0);
    check("R10", "reset rx", {rx_vo, rx_lo[14:0]}, 16'h0);
    check("R10", "reset msb", {14'b0, tx_wo[15], rx_lo[15]}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (lins[i]) begin
      step(1, 0, 0, 0, 0, 0, 1, lins[i], 0, 16'h0);
      step(1, 1, 0, 0, 0, 0, 1, lins[i], 0, 16'h0);
      step(0, 0, 0, 0, 0, 0, 1, lins[i], 1, lins[i]);
      step(0, 0, 1, 0, 0, 1, 1, lins[i], 1, lins[i]);
    end
    foreach (codes[i]) begin
      step(0, 0, 0, 1, 0, 0, 0, 16'h0, 1, {codes[i], 8'h3c});
      step(0, 0, 0, 1, 1, 0, 0, 16'h0, 1, {codes[i], 8'hc3});
      step(1, 1, 0, 0, 0, 0, 1, 16'h1234, 1, {codes[i], 8'h5a});
    end
    for (int k = 0; k < 256; k++) begin
      step(0, 0, 0, 1, k[0], 0, 1, 16'(k * 131), 1, {8'(k), 8'h00});
      step(0, 0, 0, 1, ~k[0], 0, 0, 16'h0, 1, {8'(k), 8'hff});
    end
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] c;
      c = 6'($urandom);
      step(c[0], c[1], c[2], c[3], c[4], c[5], ($urandom % 4) != 0, 16'($urandom),
           ($urandom % 4) != 0, 16'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule